// File: doc/BRIEF.md
# Dual-Mode DDS Video Clock Generator

This block makes a video pixel clock out of the system clock by direct digital synthesis. A 32-bit phase accumulator advances by a programmed step. Its most significant bit is the synthesized clock. Software writes a 32-bit frequency word. The top bit of that word picks the operating mode, and the lower 31 bits form the phase step.

In the fine mode, the accumulator takes nine sub-steps for every system clock, so an output edge can be placed to within one ninth of a system period. In the compatibility mode, it takes three sub-steps per clock and so runs at one third of the fine rate. The hardware models the sub-steps as an unrolled adder chain. Each system cycle, the block reports the following:
- whether an output rising edge fell inside that cycle;
- at which sub-step the edge fell;
- which mode is active.

Downstream logic in the system clock domain can use the edge pulse as a clock enable.

Top module: `dds_vclk_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, `vclk_out`, `edge_en`, `edge_sub` and `mode_fine` are all 0, and the phase accumulator is zero.
- R2: `mode_fine` equals bit 31 of the most recently written frequency word. It changes at the first clock edge that samples `freq_wr` high.
- R3: The phase step is bits 30:0 of the frequency word, zero-extended, in both modes. Bit 31 never adds to the step.
- R4: With bit 31 set, the accumulator advances by nine steps per clock, modulo 2^32. Over C cycles from phase zero, the count of `edge_en` pulses is floor((9·C·step + 2^31) / 2^32).
- R5: With bit 31 clear, the accumulator advances by three steps per clock. The same count formula holds with 3 in place of 9, and `edge_sub` never exceeds 3.
- R6: `vclk_out` is bit 31 of the accumulator after the last sub-step of each clock.
- R7: `edge_en` is high for exactly the cycles whose sub-step chain contains a 0-to-1 transition of bit 31. Every cycle in which `vclk_out` rises has `edge_en` high.
- R8: `edge_sub` gives the 1-based index of the first sub-step in that cycle at which bit 31 rose, and is 0 when `edge_en` is low.
- R9: A new frequency word is first used for the advance at the clock after the one that samples the write. The write does not alter the accumulator phase.
- R10: Without a write, the held frequency word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_wr | input | 1 | Write strobe for the frequency word |
| freq_word | input | 32 | Frequency word: bit 31 selects the mode, bits 30:0 give the step |
| vclk_out | output | 1 | Synthesized clock (accumulator MSB) |
| edge_en | output | 1 | One-cycle pulse when a rising edge of the synthesized clock fell in the cycle |
| edge_sub | output | 4 | Sub-step index of that rising edge, 0 if none |
| mode_fine | output | 1 | 1 in the nine-sub-step mode, 0 in the three-sub-step mode |

## Verification
The assertions assume that a whole cycle's advance, the sub-step count times the step, stays below 2^32. Under that assumption the accumulator's MSB rises at most once per cycle, and a rise of `vclk_out` across a cycle always implies a rise inside the chain. Every word the stimulus programs is chosen with this margin: fine-mode steps stay below 0x1C71C71C, and compatibility-mode steps stay below 0x55555556. Each measured run begins from a reset, so the accumulator starts at zero and the edge count follows the closed-form formula exactly.

// File: rtl/dds_vclk_pkg.sv
package dds_vclk_pkg;

  // Number of accumulator sub-steps taken in one system clock.
  function automatic int unsigned sub_count(input logic fine,
                                            input int unsigned fine_subs,
                                            input int unsigned slow_subs);
    return fine ? fine_subs : slow_subs;
  endfunction

  // A rising edge of the synthesized clock between two adjacent taps.
  function automatic logic msb_rise(input logic prev_msb, input logic next_msb);
    return ~prev_msb & next_msb;
  endfunction

endpackage

// File: rtl/dds_vclk_word_reg.sv
module dds_vclk_word_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_q,
  output logic [W-2:0] step,
  output logic         fine
);

  always_ff @(posedge clk) begin
    if (!rst_n)  word_q <= '0;
    else if (wr) word_q <= word_in;
  end

  // Mode bit is the top bit; the remainder is the step (R3).
  assign fine = word_q[W-1];
  assign step = word_q[W-2:0];

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(wr)) |-> $stable(word_q));

  a_r2_mode_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr)) |-> (fine == $past(word_in[W-1])));

endmodule

// File: rtl/dds_vclk_chain.sv
module dds_vclk_chain
  import dds_vclk_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter int unsigned FINE_SUBS = 9,
  parameter int unsigned SLOW_SUBS = 3,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [W-1:0]     phase_in,
  input  logic [W-2:0]     step,
  input  logic             fine,
  output logic [W-1:0]     phase_out,
  output logic             rise_any,
  output logic [IDX_W-1:0] rise_idx
);

  localparam int unsigned MAX_SUBS = (FINE_SUBS > SLOW_SUBS) ? FINE_SUBS : SLOW_SUBS;

  logic [W-1:0]      tap [0:MAX_SUBS];
  logic [MAX_SUBS:1] rise;
  logic [W-1:0]      step_ext;
  int unsigned       active_n;

  assign step_ext = {1'b0, step};
  assign active_n = sub_count(fine, FINE_SUBS, SLOW_SUBS);
  assign tap[0]   = phase_in;

  // Unrolled sub-phase adders; stages beyond the active count pass through.
  for (genvar g = 1; g <= int'(MAX_SUBS); g++) begin : g_sub
    assign tap[g]  = tap[g-1] + ((g <= active_n) ? step_ext : '0);
    assign rise[g] = msb_rise(tap[g-1][W-1], tap[g][W-1]);
  end

  assign phase_out = tap[MAX_SUBS];
  assign rise_any  = |rise;

  // First (lowest) sub-step at which the MSB rose.
  always_comb begin
    rise_idx = '0;
    for (int i = int'(MAX_SUBS); i >= 1; i--) begin
      if (rise[i]) rise_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/dds_vclk_gen.sv
module dds_vclk_gen #(
  parameter int unsigned W         = 32,
  parameter int unsigned FINE_SUBS = 9,
  parameter int unsigned SLOW_SUBS = 3,
  parameter int unsigned IDX_W     = $clog2(((FINE_SUBS > SLOW_SUBS) ? FINE_SUBS : SLOW_SUBS) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freq_wr,
  input  logic [W-1:0]     freq_word,
  output logic             vclk_out,
  output logic             edge_en,
  output logic [IDX_W-1:0] edge_sub,
  output logic             mode_fine
);

  logic [W-1:0]     word_q;
  logic [W-2:0]     step_w;
  logic             fine_w;
  logic [W-1:0]     phase_q;
  logic [W-1:0]     phase_nxt;
  logic             rise_any_w;
  logic [IDX_W-1:0] rise_idx_w;

  dds_vclk_word_reg #(.W(W)) word_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (freq_wr),
    .word_in (freq_word),
    .word_q  (word_q),
    .step    (step_w),
    .fine    (fine_w)
  );

  dds_vclk_chain #(
    .W(W), .FINE_SUBS(FINE_SUBS), .SLOW_SUBS(SLOW_SUBS), .IDX_W(IDX_W)
  ) chain_i (
    .phase_in  (phase_q),
    .step      (step_w),
    .fine      (fine_w),
    .phase_out (phase_nxt),
    .rise_any  (rise_any_w),
    .rise_idx  (rise_idx_w)
  );

  // Accumulator and edge markers; a write never touches the phase (R9).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= '0;
      edge_en  <= 1'b0;
      edge_sub <= '0;
    end else begin
      phase_q  <= phase_nxt;
      edge_en  <= rise_any_w;
      edge_sub <= rise_idx_w;
    end
  end

  assign vclk_out  = phase_q[W-1];
  assign mode_fine = fine_w;

  logic fine_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) fine_prev <= 1'b0;
    else        fine_prev <= fine_w;
  end

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_en |-> (edge_sub == '0));

  a_r8_edge_indexed: assert property (@(posedge clk) disable iff (!rst_n)
    edge_en |-> (edge_sub != '0));

  a_r5_slow_range: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_prev |-> (edge_sub <= IDX_W'(SLOW_SUBS)));

  a_r4_fine_range: assert property (@(posedge clk) disable iff (!rst_n)
    edge_sub <= IDX_W'(FINE_SUBS));

  a_r7_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vclk_out) |-> edge_en);

endmodule

// File: tb/dds_vclk_gen_tb.sv
`timescale 1ns/1ps
module dds_vclk_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freq_wr = 1'b0;
  logic [31:0] freq_word = '0;
  logic        vclk_out;
  logic        edge_en;
  logic [3:0]  edge_sub;
  logic        mode_fine;

  always #2 clk = ~clk;

  dds_vclk_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_wr   (freq_wr),
    .freq_word (freq_word),
    .vclk_out  (vclk_out),
    .edge_en   (edge_en),
    .edge_sub  (edge_sub),
    .mode_fine (mode_fine)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [31:0] word;
    logic [31:0] cycles;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{word: 32'h8123_4567, cycles: 32'd65536},  // R4 long run, fine
    '{word: 32'h0555_5555, cycles: 32'd65536},  // R5 long run, compatibility
    '{word: 32'h9C00_0000, cycles: 32'd4096},   // R4 near the fine step limit
    '{word: 32'h3FFF_FFFF, cycles: 32'd4096},   // R5 large slow step
    '{word: 32'h8000_0001, cycles: 32'd4096},   // R4 minimal step
    '{word: 32'h0000_0000, cycles: 32'd2048}    // R5 zero step
  };

  // Total phase advance from the requirements: steps per clock times step.
  function automatic longint unsigned advance(input logic [31:0] w, input longint unsigned c);
    longint unsigned n = w[31] ? 64'd9 : 64'd3;
    return c * n * {33'd0, w[30:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    freq_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive a write for one cycle; returns at the negedge after it was sampled.
  task automatic write_word(input logic [31:0] w);
    freq_wr = 1'b1;
    freq_word = w;
    @(negedge clk);
    freq_wr = 1'b0;
  endtask

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(vclk_out == 1'b0, "R1", "vclk in reset", vclk_out, 0);
    check(edge_en == 1'b0, "R1", "edge_en in reset", edge_en, 0);
    check(edge_sub == 4'd0, "R1", "edge_sub in reset", edge_sub, 0);
    check(mode_fine == 1'b0, "R1", "mode in reset", mode_fine, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vclk_out == 1'b0 && edge_en == 1'b0, "R1", "idle after reset", {vclk_out, edge_en}, 0);

    // R4 R5 R6 R7: average frequency over table entries
    for (int v = 0; v < NVEC; v++) begin
      longint unsigned adv;
      longint unsigned cnt;
      do_reset();
      write_word(VECS[v].word);
      check(mode_fine == VECS[v].word[31], "R2", "mode after write", mode_fine, VECS[v].word[31]);
      cnt = 0;
      for (int c = 0; c < int'(VECS[v].cycles); c++) begin
        @(negedge clk);
        if (edge_en) cnt++;
      end
      adv = advance(VECS[v].word, VECS[v].cycles);
      check(cnt == ((adv + 64'h8000_0000) >> 32),
            VECS[v].word[31] ? "R4" : "R5", "edge count", cnt, (adv + 64'h8000_0000) >> 32);
      check(vclk_out == adv[31], "R6", "final vclk", vclk_out, adv[31]);
    end

    // R8 R6 R3: fine mode, step 2^28, rise at sub-step 8 then 6
    do_reset();
    write_word(32'h9000_0000);
    @(negedge clk);
    check(edge_en == 1'b1, "R7", "fine cycle1 edge", edge_en, 1);
    check(edge_sub == 4'd8, "R8", "fine cycle1 index", edge_sub, 8);
    check(vclk_out == 1'b1, "R6", "fine cycle1 vclk", vclk_out, 1);
    @(negedge clk);
    check(edge_en == 1'b0 && edge_sub == 4'd0, "R8", "fine cycle2 no edge", edge_sub, 0);
    check(vclk_out == 1'b0, "R6", "fine cycle2 vclk after wrap", vclk_out, 0);
    @(negedge clk);
    check(edge_sub == 4'd6, "R8", "fine cycle3 index", edge_sub, 6);
    check(vclk_out == 1'b1, "R6", "fine cycle3 vclk", vclk_out, 1);

    // R5 R3: compatibility mode, same step, rise at sub-step 2 of cycle 3
    do_reset();
    write_word(32'h1000_0000);
    check(mode_fine == 1'b0, "R2", "slow mode flag", mode_fine, 0);
    @(negedge clk);
    check(edge_en == 1'b0, "R5", "slow cycle1", edge_en, 0);
    @(negedge clk);
    check(edge_en == 1'b0, "R5", "slow cycle2", edge_en, 0);
    @(negedge clk);
    check(edge_en == 1'b1 && edge_sub == 4'd2, "R5", "slow cycle3 index", edge_sub, 2);

    // R9: mid-run write keeps phase and applies one clock later
    do_reset();
    write_word(32'h9000_0000);
    @(negedge clk);                    // phase = 9 * 2^28
    freq_wr = 1'b1;
    freq_word = 32'h1000_0000;
    @(negedge clk);                    // advance still fine: phase = 2 * 2^28
    freq_wr = 1'b0;
    check(mode_fine == 1'b0, "R9", "mode switched", mode_fine, 0);
    check(vclk_out == 1'b0 && edge_en == 1'b0, "R9", "old word used for write cycle",
          {vclk_out, edge_en}, 0);
    @(negedge clk);                    // phase = 5 * 2^28
    check(edge_en == 1'b0 && vclk_out == 1'b0, "R9", "phase kept, no edge yet", {vclk_out, edge_en}, 0);
    @(negedge clk);                    // phase = 8 * 2^28, rise at sub-step 3
    check(edge_en == 1'b1 && edge_sub == 4'd3, "R9", "edge index after switch", edge_sub, 3);
    check(vclk_out == 1'b1, "R9", "vclk after switch", vclk_out, 1);

    // R10: freq_word changes without a strobe are ignored
    freq_word = 32'h8FFF_FFFF;
    repeat (4) @(negedge clk);
    check(mode_fine == 1'b0, "R10", "mode held without write", mode_fine, 0);
    // still slow step 2^28: phase 8 -> 20 -> wrap to 4*2^28 after four cycles
    check(vclk_out == 1'b0, "R10", "vclk with held step", vclk_out, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < 190000; n++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule